// File: doc/BRIEF.md
# Branch Trace History Buffer

This block keeps a short history of the taken program-flow changes that a processor pipeline reports. Each report arrives as a one-cycle strobe carrying two addresses, the branch origin and the branch target. The block stores the pair as one entry in a last-in, first-out store of `DEPTH` entries. A debugger or software then reads the history back, newest branch first, through a small synchronous register port.

Three registers sit on a 2-bit register address. Control is at 0: bit 0 is power, bit 1 is enable, bit 2 keeps old entries when the store is full, and bit 3 suppresses repeats. Status is at 1 and returns the count of complete entries held. Data is at 2. Each entry comes out of the data register as two words: the target first, then the origin. The second word pops the entry. Capture runs only while power and enable are both set. Writing control with power clear empties the store.

Top module: `brtrace_hist`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 and `bus_rdata` is 0.
- R2: A capture strobe is stored only when control bit 0 (power) and bit 1 (enable) are both 1. Control values 0x0, 0x1 and 0x2 store nothing, and 0x3 stores the pair.
- R3: A read of address 1 returns the number of complete entries held, zero-extended. One capture gives 1.
- R4: Successive reads of address 2 return the newest entry's target address and then its origin address, working from the newest entry to the oldest. A jump from 0x2C0 to 0x2D2 reads back as 0x2D2 and then 0x2C0.
- R5: The entry count is unchanged after the target read and drops by one after the origin read.
- R6: Writing 0x1 to control after captures stops further capture and keeps the stored entries readable.
- R7: A control write with bit 0 clear empties the store and returns the word select to the target word.
- R8: With control bit 2 clear and the store full, a new capture replaces the oldest entry and the count stays at `DEPTH`.
- R9: With control bit 2 set and the store full, a new capture is discarded and the stored entries are unchanged.
- R10: With control bit 3 set, a capture whose origin and target both equal those of the newest held entry is not stored.
- R11: A read of address 2 while the store is empty returns 0 and changes neither the count nor the contents.
- R12: A capture and a data read in the same cycle are handled read first: the read is served from the old contents, then the capture is stored, and an accepted capture returns the word select to the target word.
- R13: Read data appears on `bus_rdata` in the cycle after the read is issued. Control reads return bits [3:0] as written, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | One-cycle strobe for a taken branch |
| cap_src | input | AW | Branch origin address |
| cap_dst | input | AW | Branch target address |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | AW | Write data |
| bus_rdata | output | AW | Read data, valid one cycle after the read |

## Verification
The bench builds the block with `DEPTH` = 4 and `AW` = 32. The small depth lets a few captures fill the store, so the overwrite and keep-old policies at the full boundary can be exercised and a full store can be drained completely within a short run. The wide address keeps full 32-bit addresses, so the target and origin words are easy to tell apart on readback.

// File: rtl/brt_pkg.sv
package brt_pkg;

  // Register select decode. The numeric values are visible to software.
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DATA = 2'd2,
    REG_NONE = 2'd3
  } brt_reg_e;

  // Control bit positions.
  localparam int CTL_W        = 4;
  localparam int CTL_POWER    = 0;
  localparam int CTL_ENABLE   = 1;
  localparam int CTL_KEEP_OLD = 2;
  localparam int CTL_SQUASH   = 3;

  // Circular pointer stepping for a ring of 'depth' slots.
  function automatic int ring_next(input int p, input int depth);
    return (p >= depth - 1) ? 0 : p + 1;
  endfunction

  function automatic int ring_prev(input int p, input int depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

  // Occupancy after one push: saturates at depth (oldest is overwritten).
  function automatic int fill_after_push(input int fill_now, input int depth);
    return (fill_now >= depth) ? depth : fill_now + 1;
  endfunction

endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CTL_W-1:0] wr_bits,
  output logic [CTL_W-1:0] ctrl_q,
  output logic             trace_on,
  output logic             keep_old,
  output logic             squash_repeat,
  output logic             flush
);

  logic ctrl_wr;

  assign ctrl_wr = reg_wr && (reg_addr == REG_CTRL);
  // A control write that drops power empties the history.
  assign flush   = ctrl_wr && !wr_bits[CTL_POWER];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wr_bits;
    end
  end

  assign trace_on      = ctrl_q[CTL_POWER] && ctrl_q[CTL_ENABLE];
  assign keep_old      = ctrl_q[CTL_KEEP_OLD];
  assign squash_repeat = ctrl_q[CTL_SQUASH];

endmodule

// File: rtl/brt_lifo.sv
module brt_lifo
  import brt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop,
  input  logic          flush,
  input  logic          keep_old,
  input  logic          squash_repeat,
  input  logic [AW-1:0] in_src,
  input  logic [AW-1:0] in_dst,
  output logic [AW-1:0] top_src,
  output logic [AW-1:0] top_dst,
  output logic [FW-1:0] fill,
  output logic          push_acc
);

  typedef struct packed {
    logic [AW-1:0] src;
    logic [AW-1:0] dst;
  } pair_t;

  pair_t         slots [DEPTH];
  logic [PW-1:0] wptr;       // next free slot; newest sits just below it
  logic [PW-1:0] top_idx;
  logic [PW-1:0] base;       // slot a push lands in after any same-cycle pop
  logic [PW-1:0] below_base;
  logic [FW-1:0] fill_mid;   // occupancy after the pop, before the push
  logic          full_mid;
  logic          is_repeat;

  assign top_idx    = PW'(ring_prev(int'(wptr), DEPTH));
  assign top_src    = slots[top_idx].src;
  assign top_dst    = slots[top_idx].dst;

  // Read is resolved first: a pop frees the newest slot for this cycle's push.
  assign base       = pop ? top_idx : wptr;
  assign fill_mid   = pop ? (fill - FW'(1)) : fill;
  assign below_base = PW'(ring_prev(int'(base), DEPTH));
  assign full_mid   = (fill_mid == FW'(DEPTH));
  assign is_repeat  = (fill_mid != '0) &&
                      (slots[below_base].src == in_src) &&
                      (slots[below_base].dst == in_dst);

  assign push_acc = push_req && !flush &&
                    !(full_mid && keep_old) &&
                    !(squash_repeat && is_repeat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      fill <= '0;
    end else if (flush) begin
      wptr <= '0;
      fill <= '0;
    end else if (push_acc) begin
      wptr <= PW'(ring_next(int'(base), DEPTH));
      fill <= FW'(fill_after_push(int'(fill_mid), DEPTH));
    end else if (pop) begin
      wptr <= base;
      fill <= fill_mid;
    end
  end

  // Storage carries no reset; occupancy alone says which slots are live.
  always_ff @(posedge clk) begin
    if (push_acc) begin
      slots[base] <= '{src: in_src, dst: in_dst};
    end
  end

endmodule

// File: rtl/brt_rd_seq.sv
module brt_rd_seq
  import brt_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_rd,
  input  logic [FW-1:0]    fill,
  input  logic [AW-1:0]    top_src,
  input  logic [AW-1:0]    top_dst,
  input  logic [CTL_W-1:0] ctrl_q,
  input  logic             flush,
  input  logic             push_acc,
  output logic             data_rd,
  output logic             pop,
  output logic             word_sel,
  output logic [AW-1:0]    rd_data
);

  logic          nonempty;
  logic [AW-1:0] rd_next;

  assign data_rd  = reg_rd && (reg_addr == REG_DATA);
  assign nonempty = (fill != '0);
  // The origin word completes the entry and removes it.
  assign pop      = data_rd && nonempty && word_sel;

  always_comb begin
    rd_next = '0;
    if (reg_rd) begin
      case (reg_addr)
        REG_CTRL: rd_next = AW'(ctrl_q);
        REG_STAT: rd_next = AW'(fill);
        REG_DATA: rd_next = !nonempty ? '0 : (word_sel ? top_src : top_dst);
        default:  rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_sel <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_data <= rd_next;
      if (flush || push_acc) begin
        word_sel <= 1'b0;
      end else if (data_rd && nonempty) begin
        word_sel <= !word_sel;
      end
    end
  end

endmodule

// File: rtl/brtrace_hist.sv
module brtrace_hist
  import brt_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_valid,
  input  logic [AW-1:0] cap_src,
  input  logic [AW-1:0] cap_dst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_wdata,
  output logic [AW-1:0] bus_rdata
);

  // Named internal events, used by the bound checker.
  logic [CTL_W-1:0] ctrl_q;
  logic             trace_on;
  logic             keep_old;
  logic             squash_repeat;
  logic             flush;
  logic [FW-1:0]    fill;
  logic [AW-1:0]    top_src;
  logic [AW-1:0]    top_dst;
  logic             push_acc;
  logic             data_rd;
  logic             pop;
  logic             word_sel;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata[AW-1:CTL_W];

  brt_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (bus_addr),
    .reg_wr        (bus_wr),
    .wr_bits       (bus_wdata[CTL_W-1:0]),
    .ctrl_q        (ctrl_q),
    .trace_on      (trace_on),
    .keep_old      (keep_old),
    .squash_repeat (squash_repeat),
    .flush         (flush)
  );

  brt_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_req      (cap_valid && trace_on),
    .pop           (pop),
    .flush         (flush),
    .keep_old      (keep_old),
    .squash_repeat (squash_repeat),
    .in_src        (cap_src),
    .in_dst        (cap_dst),
    .top_src       (top_src),
    .top_dst       (top_dst),
    .fill          (fill),
    .push_acc      (push_acc)
  );

  brt_rd_seq #(.AW(AW), .FW(FW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (bus_addr),
    .reg_rd   (bus_rd),
    .fill     (fill),
    .top_src  (top_src),
    .top_dst  (top_dst),
    .ctrl_q   (ctrl_q),
    .flush    (flush),
    .push_acc (push_acc),
    .data_rd  (data_rd),
    .pop      (pop),
    .word_sel (word_sel),
    .rd_data  (bus_rdata)
  );

endmodule

// File: rtl/brt_checker.sv
module brt_checker #(
  parameter int AW    = 32,
  parameter int DEPTH = 16,
  parameter int FW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_acc,
  input logic          trace_on,
  input logic          flush,
  input logic [FW-1:0] fill,
  input logic          data_rd,
  input logic          word_sel,
  input logic          pop,
  input logic [AW-1:0] rd_data
);

  AST_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |-> trace_on);  // R2

  AST_FILL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));  // R8

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (fill == '0) && !word_sel);  // R7

  AST_TARGET_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && (fill != '0) && !word_sel && !push_acc && !flush) |=> (fill == $past(fill)));  // R5

  AST_ORIGIN_READ_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push_acc && !flush) |=> (fill == $past(fill) - FW'(1)));  // R5

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && (fill == '0)) |=> (rd_data == '0));  // R11

  AST_EMPTY_READ_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && (fill == '0) && !push_acc) |=> (fill == '0));  // R11

  AST_PUSH_SELECTS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    push_acc |=> !word_sel);  // R12

endmodule

bind brtrace_hist brt_checker #(.AW(AW), .DEPTH(DEPTH), .FW(FW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push_acc (push_acc),
  .trace_on (trace_on),
  .flush    (flush),
  .fill     (fill),
  .data_rd  (data_rd),
  .word_sel (word_sel),
  .pop      (pop),
  .rd_data  (bus_rdata)
);

// File: tb/brtrace_hist_tb_top.sv
module brtrace_hist_tb_top;

  localparam int AW    = 32;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cap_valid = 1'b0;
  logic [AW-1:0] cap_src = '0;
  logic [AW-1:0] cap_dst = '0;
  logic [1:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_wdata = '0;
  logic [AW-1:0] bus_rdata;

  always #4 clk = !clk;  // 125 MHz

  brtrace_hist #(.AW(AW), .DEPTH(DEPTH)) dut_i (.*);

  int n_checks = 0;
  int n_fails  = 0;

  // Scoreboard: expected read results and the requirement each one covers.
  logic [AW-1:0] exp_val [$];
  string         exp_tag [$];

  // Reference history: entries packed as {origin, target}, newest at the back.
  logic [2*AW-1:0] ref_q [$];
  logic            ref_sel = 1'b0;
  logic [3:0]      ref_ctrl = '0;

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: a read issued before a rising edge shows on bus_rdata after it.
  logic rd_d = 1'b0;
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_val.size() == 0) begin
        check("R13 unexpected read data", bus_rdata, 'x);
      end else begin
        check(exp_tag.pop_front(), bus_rdata, exp_val.pop_front());
      end
    end
  end

  // Reference behaviour of one capture strobe.
  function automatic void model_push(input logic [AW-1:0] s, input logic [AW-1:0] d);
    if (!(ref_ctrl[0] && ref_ctrl[1])) return;
    if (ref_ctrl[3] && ref_q.size() > 0 && ref_q[$] == {s, d}) return;
    if (ref_q.size() == DEPTH) begin
      if (ref_ctrl[2]) return;
      void'(ref_q.pop_front());
    end
    ref_q.push_back({s, d});
    ref_sel = 1'b0;
  endfunction

  // Reference behaviour of one data-register read; returns the expected word.
  function automatic logic [AW-1:0] model_data_read();
    logic [2*AW-1:0] e;
    if (ref_q.size() == 0) return '0;
    e = ref_q[$];
    if (!ref_sel) begin
      ref_sel = 1'b1;
      return e[AW-1:0];
    end
    ref_sel = 1'b0;
    void'(ref_q.pop_back());
    return e[2*AW-1:AW];
  endfunction

  // Driver tasks: each starts at a falling edge and ends at the next one.
  task automatic wr_ctrl(input logic [AW-1:0] v);
    bus_addr = 2'd0; bus_wdata = v; bus_wr = 1'b1;
    ref_ctrl = v[3:0];
    if (!v[0]) begin
      ref_q.delete();
      ref_sel = 1'b0;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic capture(input logic [AW-1:0] s, input logic [AW-1:0] d);
    cap_src = s; cap_dst = d; cap_valid = 1'b1;
    model_push(s, d);
    @(negedge clk);
    cap_valid = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input string tag);
    logic [AW-1:0] e;
    case (a)
      2'd0:    e = AW'(ref_ctrl);
      2'd1:    e = AW'(ref_q.size());
      2'd2:    e = model_data_read();
      default: e = '0;
    endcase
    exp_val.push_back(e);
    exp_tag.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic cap_and_read(input logic [AW-1:0] s, input logic [AW-1:0] d, input string tag);
    exp_val.push_back(model_data_read());
    exp_tag.push_back(tag);
    model_push(s, d);
    cap_src = s; cap_dst = d; cap_valid = 1'b1;
    bus_addr = 2'd2; bus_rd = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, '0);
    rd_reg(2'd1, "R1 status after reset");
    rd_reg(2'd0, "R1 control after reset");

    // R2: each partial control setting stores nothing.
    wr_ctrl(32'h0); capture(32'h100, 32'h110);
    wr_ctrl(32'h2); capture(32'h2c0, 32'h2d2);
    rd_reg(2'd1, "R2 enable without power");
    wr_ctrl(32'h1); capture(32'h120, 32'h130);
    rd_reg(2'd1, "R2 power without enable");

    // R2/R3/R4/R5/R6: one jump, freeze, then read out.
    wr_ctrl(32'h3); capture(32'h2c0, 32'h2d2);
    wr_ctrl(32'h1); capture(32'h400, 32'h404);
    rd_reg(2'd1, "R3 one entry after freeze R6");
    rd_reg(2'd2, "R4 target word");
    rd_reg(2'd1, "R5 count after target read");
    rd_reg(2'd2, "R4 origin word");
    rd_reg(2'd1, "R5 count after origin read");
    rd_reg(2'd2, "R11 empty data read");
    rd_reg(2'd1, "R11 count after empty read");
    rd_reg(2'd0, "R13 control readback");
    rd_reg(2'd3, "R13 unused address");

    // R4: newest-first order across several entries.
    wr_ctrl(32'h3);
    capture(32'h1000, 32'h1100);
    capture(32'h2000, 32'h2200);
    capture(32'h3000, 32'h3300);
    rd_reg(2'd1, "R3 three entries");
    for (int i = 0; i < 6; i++) rd_reg(2'd2, "R4 ordered drain");
    rd_reg(2'd1, "R5 empty after drain");

    // R7: flush mid-entry resets the word select.
    capture(32'h5000, 32'h5500);
    rd_reg(2'd2, "R7 target before flush");
    wr_ctrl(32'h0);
    rd_reg(2'd1, "R7 count after flush");
    wr_ctrl(32'h3);
    capture(32'h6000, 32'h6600);
    rd_reg(2'd2, "R7 target word after flush");
    rd_reg(2'd2, "R7 origin word after flush");

    // R8: overwrite the oldest when full.
    for (int i = 0; i < 6; i++) capture(32'h7000 + i * 16, 32'h7800 + i * 16);
    rd_reg(2'd1, "R8 count saturates");
    for (int i = 0; i < 8; i++) rd_reg(2'd2, "R8 newest entries kept");
    rd_reg(2'd1, "R8 empty after drain");

    // R9: keep the old entries when full.
    wr_ctrl(32'h7);
    for (int i = 0; i < 5; i++) capture(32'h9000 + i * 16, 32'h9800 + i * 16);
    rd_reg(2'd1, "R9 count at depth");
    rd_reg(2'd2, "R9 newest is fourth capture");
    rd_reg(2'd2, "R9 origin of fourth capture");
    wr_ctrl(32'h0);

    // R10: repeat suppression.
    wr_ctrl(32'hb);
    capture(32'ha000, 32'ha100);
    capture(32'ha000, 32'ha100);
    capture(32'hb000, 32'hb100);
    capture(32'ha000, 32'ha100);
    rd_reg(2'd1, "R10 repeats dropped");
    rd_reg(2'd0, "R13 control with squash bit");
    for (int i = 0; i < 6; i++) rd_reg(2'd2, "R10 drain");

    // R12: capture and read in the same cycle.
    wr_ctrl(32'h3);
    capture(32'hc000, 32'hc100);
    cap_and_read(32'hd000, 32'hd100, "R12 read served before capture");
    rd_reg(2'd2, "R12 word select back on target");
    rd_reg(2'd2, "R12 origin of new entry");
    capture(32'he000, 32'he100);
    rd_reg(2'd2, "R12 target before combined pop");
    cap_and_read(32'hf000, 32'hf100, "R12 origin popped with capture");
    rd_reg(2'd1, "R12 count after combined cycle");
    for (int i = 0; i < 4; i++) rd_reg(2'd2, "R12 drain");
    rd_reg(2'd1, "R12 empty at end");

    repeat (3) @(negedge clk);
    if (exp_val.size() != 0) check("R13 reads left unanswered", AW'(exp_val.size()), '0);
    summary();
    $finish;
  end

endmodule